// File: doc/BRIEF.md
# Tick Timer with Compare Interrupt

This block is a processor tick timer built around two software-visible registers: a free-running 32-bit count and a mode word that carries a two-bit run mode, an interrupt enable, a pending flag and a 28-bit period. While it runs, the count steps once per core clock. When the low 28 bits of the count equal the period, the pending flag is set. The interrupt output is high only while pending and enable are both set.

Software uses it both as a monotonic time source and as an event timer. To schedule the next event it reads the count, adds a delta, keeps the low 28 bits and writes that value as the period, with continuous mode and enable set. To acknowledge the event it rewrites the mode word with pending and enable at zero. A restart mode clears the count on a match, and a one-shot mode freezes it there.

The register port is plain control, with no valid/ready pair. A write is accepted in the cycle it is presented, and a read is combinational. The port never applies back-pressure, so software may write either register in any cycle.

Top module: `tick_timer`

## Requirements
- R1: After reset both registers read zero and `irq` is low, so the timer is off with nothing pending.
- R2: `reg_addr` 0 selects the mode word and 1 selects the count. `reg_rdata` follows the selected register combinationally, and a write with `reg_we` high takes effect at the next clock edge. Mode word layout: bits 31:30 run mode (00 off, 01 restart, 10 one-shot, 11 continuous), bit 29 interrupt enable, bit 28 pending, bits 27:0 period. A mode write stores the written word as given.
- R3: In off mode (00) the count holds its value, and no match is detected even when the count's low bits equal the period.
- R4: In continuous mode (11) the count rises by one per clock, wraps from 0xFFFFFFFF to 0, and is never reloaded or stopped by a match.
- R5: A match is detected in a cycle where the timer is not off and count bits 27:0 equal the period, whatever count bits 31:28 hold. The pending flag is set at the clock edge that ends that cycle.
- R6: Once set, pending stays set until a mode write. Writing the mode word with pending 0 clears it, and the run mode then takes the written value.
- R7: `irq` is high exactly when interrupt enable and pending are both set. With enable at 0, pending is still set and readable while `irq` stays low.
- R8: In restart mode (01), a match clears the whole 32-bit count to zero at the next edge, and counting continues from there.
- R9: In one-shot mode (10), a match leaves the count at the matching value and changes the run-mode field to 00, so the count holds from then on.
- R10: A count write takes priority over that cycle's increment: the count takes the written value exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 1 | Register select: 0 mode word, 1 count |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read of the selected register |
| irq | output | 1 | Interrupt request, enable AND pending |

## Verification
The bench sweeps the distance from the loaded count to the period, from zero up to ten cycles, with the count's top nibble nonzero. A design that compared all 32 bits would never fire, and one with an off-by-one match edge would raise pending a cycle early or late. It also checks that the count keeps climbing after a match: a design that reloaded in continuous mode would break the time source. Separate cases cover the restart clear, the one-shot freeze with its run field dropping to 00, the wrap at 32 bits, a period equal to the count while off (which must stay silent), and a pending flag with enable low that must not reach `irq`.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  typedef enum logic [1:0] {
    TT_OFF     = 2'b00,
    TT_RESTART = 2'b01,
    TT_ONCE    = 2'b10,
    TT_FREE    = 2'b11
  } tt_run_e;

  localparam logic TT_SEL_MODE  = 1'b0;
  localparam logic TT_SEL_COUNT = 1'b1;

endpackage

// File: rtl/tick_cmp.sv
module tick_cmp
  import tick_timer_pkg::*;
#(
  parameter int PER_W = 28
) (
  input  tt_run_e          run,
  input  logic [PER_W-1:0] cnt_low,
  input  logic [PER_W-1:0] period,
  output logic             match
);

  logic active;

  always_comb begin
    active = (run != TT_OFF);
    match  = active && (cnt_low == period);
  end

endmodule

// File: rtl/tick_ctrl.sv
module tick_ctrl
  import tick_timer_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int PER_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  input  logic             match,
  output tt_run_e          run,
  output logic             ie,
  output logic             ip,
  output logic [PER_W-1:0] period,
  output logic [REG_W-1:0] word
);

  localparam int RUN_HI = REG_W - 1;
  localparam int RUN_LO = REG_W - 2;
  localparam int IE_BIT = REG_W - 3;
  localparam int IP_BIT = REG_W - 4;
  localparam int GAP_W  = REG_W - 4 - PER_W;

  tt_run_e          run_q;
  logic             ie_q;
  logic             ip_q;
  logic [PER_W-1:0] per_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= TT_OFF;
      ie_q  <= 1'b0;
      ip_q  <= 1'b0;
      per_q <= '0;
    end else if (we) begin
      run_q <= tt_run_e'(wdata[RUN_HI:RUN_LO]);
      ie_q  <= wdata[IE_BIT];
      ip_q  <= wdata[IP_BIT];
      per_q <= wdata[PER_W-1:0];
    end else if (match) begin
      ip_q <= 1'b1;
      if (run_q == TT_ONCE) begin
        run_q <= TT_OFF;
      end
    end
  end

  generate
    if (GAP_W > 0) begin : g_gap
      assign word = {run_q, ie_q, ip_q, {GAP_W{1'b0}}, per_q};
    end else begin : g_nogap
      assign word = {run_q, ie_q, ip_q, per_q};
    end
  endgenerate

  assign run    = run_q;
  assign ie     = ie_q;
  assign ip     = ip_q;
  assign period = per_q;

  AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !we) |=> ip_q); // R5

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ip_q && !we) |=> ip_q); // R6

  AST_ONCE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !we && run_q == TT_ONCE) |=> (run_q == TT_OFF)); // R9

endmodule

// File: rtl/tick_count.sv
module tick_count
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tt_run_e          run,
  input  logic             match,
  input  logic             we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] cnt_inc;

  always_comb begin
    cnt_inc = cnt_q + CNT_W'(1);
    cnt_d   = cnt_q;
    if (we) begin
      cnt_d = wdata;
    end else begin
      unique case (run)
        TT_OFF:     cnt_d = cnt_q;
        TT_FREE:    cnt_d = cnt_inc;
        TT_RESTART: cnt_d = match ? '0 : cnt_inc;
        TT_ONCE:    cnt_d = match ? cnt_q : cnt_inc;
        default:    cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run == TT_OFF && !we) |=> $stable(cnt_q)); // R3

  AST_FREE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run == TT_FREE && !we) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R4

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (run == TT_RESTART && match && !we) |=> (cnt_q == '0)); // R8

  AST_CNT_WR: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (cnt_q == $past(wdata))); // R10

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PER_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_addr,
  input  logic             reg_we,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             irq
);

  tt_run_e          run;
  logic             ie;
  logic             ip;
  logic             match;
  logic [PER_W-1:0] period;
  logic [CNT_W-1:0] mode_word;
  logic [CNT_W-1:0] cnt;
  logic             mode_we;
  logic             cnt_we;

  assign mode_we = reg_we && (reg_addr == TT_SEL_MODE);
  assign cnt_we  = reg_we && (reg_addr == TT_SEL_COUNT);

  tick_cmp #(.PER_W(PER_W)) u_cmp (
    .run     (run),
    .cnt_low (cnt[PER_W-1:0]),
    .period  (period),
    .match   (match)
  );

  tick_ctrl #(.REG_W(CNT_W), .PER_W(PER_W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (mode_we),
    .wdata  (reg_wdata),
    .match  (match),
    .run    (run),
    .ie     (ie),
    .ip     (ip),
    .period (period),
    .word   (mode_word)
  );

  tick_count #(.CNT_W(CNT_W)) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .match (match),
    .we    (cnt_we),
    .wdata (reg_wdata),
    .cnt   (cnt)
  );

  assign reg_rdata = (reg_addr == TT_SEL_COUNT) ? cnt : mode_word;
  assign irq       = ie && ip;

  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_we && !reg_wdata[CNT_W-4]) |=> !irq); // R6

endmodule

// File: tb/tick_timer_bench.sv
module tick_timer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_addr = 1'b0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tick_timer u_tick_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq)
  );

  function automatic logic [31:0] mk(logic [1:0] run, logic ie, logic ip, logic [27:0] per);
    return {run, ie, ip, per};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [31:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_we    = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  task automatic rd(logic a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] x;
    logic [27:0] p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(1'b0, v); check("R1 mode", v, 32'h0);
    rd(1'b1, v); check("R1 count", v, 32'h0);
    check("R1 irq", {31'd0, irq}, 32'd0);

    // R2 mode readback of layout (pending written 0)
    wr(1'b0, 32'h2ABC_DEF1);
    rd(1'b0, v); check("R2 readback", v, 32'h2ABC_DEF1);
    check("R2 irq", {31'd0, irq}, 32'd0);

    // R3 off mode: count holds, equal period raises nothing
    wr(1'b0, mk(2'b00, 1'b1, 1'b0, 28'h55));
    wr(1'b1, 32'h55);
    repeat (6) @(negedge clk);
    rd(1'b1, v); check("R3 hold", v, 32'h55);
    rd(1'b0, v); check("R3 no pending", {31'd0, v[28]}, 32'd0);
    check("R3 irq", {31'd0, irq}, 32'd0);

    // R4 / R10 continuous and 32-bit wrap, count write exact
    wr(1'b0, mk(2'b11, 1'b0, 1'b0, 28'h100));
    wr(1'b1, 32'hFFFF_FFFE);
    rd(1'b1, v); check("R10 write priority", v, 32'hFFFF_FFFE);
    for (int j = 1; j <= 4; j++) begin
      @(negedge clk);
      rd(1'b1, v); check("R4 wrap step", v, 32'hFFFF_FFFE + 32'(j));
    end

    // R5 / R7 / R4 sweep of distance to the period, top nibble nonzero
    for (int d = 0; d <= 10; d++) begin
      logic ie;
      ie = (d % 2 == 0);
      x = 32'hA000_0000 | 32'(d * 37 + 100);
      p = 28'(x + 32'(d));
      wr(1'b0, mk(2'b00, 1'b0, 1'b0, 28'h0));
      wr(1'b1, x);
      wr(1'b0, mk(2'b11, ie, 1'b0, p));
      for (int j = 0; j <= d + 2; j++) begin
        logic expip;
        if (j > 0) @(negedge clk);
        expip = (j >= d + 1);
        rd(1'b0, v); check("R5 pending edge", {31'd0, v[28]}, {31'd0, expip});
        check("R7 irq", {31'd0, irq}, {31'd0, expip & ie});
      end
      rd(1'b1, v); check("R4 no reload", v, x + 32'(d + 2));
    end

    // R6 pending sticky, then clear keeps run mode as written
    repeat (20) @(negedge clk);
    rd(1'b0, v); check("R6 sticky", {31'd0, v[28]}, 32'd1);
    check("R6 irq before clear", {31'd0, irq}, 32'd1);
    wr(1'b0, mk(2'b11, 1'b0, 1'b0, p));
    rd(1'b0, v); check("R6 cleared", v, mk(2'b11, 1'b0, 1'b0, p));
    check("R6 irq cleared", {31'd0, irq}, 32'd0);

    // R8 restart
    wr(1'b0, mk(2'b00, 1'b0, 1'b0, 28'h0));
    wr(1'b1, 32'h7000_0005);
    wr(1'b0, mk(2'b01, 1'b1, 1'b0, 28'h8));
    repeat (3) @(negedge clk);
    rd(1'b1, v); check("R8 at match", v, 32'h7000_0008);
    @(negedge clk);
    rd(1'b1, v); check("R8 cleared", v, 32'h0);
    check("R8 irq", {31'd0, irq}, 32'd1);
    @(negedge clk);
    rd(1'b1, v); check("R8 resumes", v, 32'h1);

    // R9 one-shot
    wr(1'b0, mk(2'b00, 1'b0, 1'b0, 28'h0));
    wr(1'b1, 32'h3000_0010);
    wr(1'b0, mk(2'b10, 1'b1, 1'b0, 28'h14));
    repeat (8) @(negedge clk);
    rd(1'b1, v); check("R9 frozen", v, 32'h3000_0014);
    rd(1'b0, v); check("R9 run off", v, mk(2'b00, 1'b1, 1'b1, 28'h14));
    check("R9 irq", {31'd0, irq}, 32'd1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule